// File: doc/BRIEF.md
# One-Time Trim Register Bank with Parity Lock

This block stores the three trim settings of a sensor amplifier: a 3-bit second-stage gain code, a 7-bit first-stage gain code and an 8-bit output offset code. Each setting has two sources. One is a volatile register that a simulate command writes. The other is a group of one-time fuse bits that a program command burns, one bit per command. Three further fuse bits are handled alongside them: a lock fuse, a test fuse and a parity fuse. Fuses are modelled as sticky flops that only a reset clears. Analog sensing of the fuses is outside this block.

A command decoder in front of the bank delivers already-framed commands as one-cycle strobes. Each strobe carries an operation code, a parameter selector and an 8-bit value. While the lock fuse is intact, the trim outputs follow the volatile registers. Once the lock fuse is burnt, the outputs come only from the fuses, simulate and program commands have no further effect, and a parity check over the fuse contents is enabled. A parity mismatch raises a safe-state output that pulls the amplifier output to ground.

A program command is accepted only when its value has exactly one bit set, and that bit must exist for the selected parameter. An accepted command starts a burn strobe that lasts a fixed, parameterised number of cycles. No other burn can start until that strobe ends.

Top module: `trim_fuse_bank`

## Requirements
- R1: After reset, all three trim outputs are 0, and `safe_o`, `blow_o`, `reject_o`, `locked_o` and `test_fuse_o` are all 0. Reset clears every fuse.
- R2: A command with `cmd_op_i`=01 (simulate) writes the low bits of `cmd_val_i` into the volatile register chosen by `cmd_sel_i`. The selector codes are 00 for second-stage gain, 01 for first-stage gain and 10 for offset. Selector 11 changes nothing. The new value appears on the outputs in the cycle after the command.
- R3: While the lock fuse is intact, the trim outputs equal the volatile registers. Burnt data fuses have no effect on the outputs.
- R4: Once the lock fuse is burnt (`locked_o`=1), the trim outputs equal the fuse contents and simulate commands are ignored.
- R5: A command with `cmd_op_i`=10 (program) is rejected in either of two cases: its value does not have exactly one bit set, or the set bit lies at or above the width of the selected parameter. For selector 11 the width is 3, where bit 0 is the lock fuse, bit 1 the test fuse and bit 2 the parity fuse. A rejected command sets `reject_o` and does not raise `blow_o`.
- R6: An accepted program command holds `blow_o` high for exactly BLOW_CYCLES cycles, starting in the cycle after the command. The addressed fuse reads as burnt when that strobe ends. At most one fuse changes per command, and a fuse never returns to 0.
- R7: A program command that arrives while `blow_o` is high is rejected, and its fuse is never burnt.
- R8: `safe_o` equals the lock fuse ANDed with the XOR of the 18 data fuses and the parity fuse. While the lock fuse is intact, `safe_o` is 0.
- R9: After the lock fuse is burnt, program commands are ignored: `blow_o` stays low and `reject_o` keeps its value.
- R10: An accepted program command clears `reject_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid_i | input | 1 | One-cycle command strobe |
| cmd_op_i | input | 2 | Operation: 01 simulate, 10 program, other codes no effect |
| cmd_sel_i | input | 2 | Parameter: 00 gain2, 01 gain1, 10 offset, 11 control fuses |
| cmd_val_i | input | 8 | Command value |
| gain2_o | output | 3 | Active second-stage gain code |
| gain1_o | output | 7 | Active first-stage gain code |
| offset_o | output | 8 | Active output offset code |
| safe_o | output | 1 | Parity error, forces the output-to-ground safe state |
| blow_o | output | 1 | Fuse burn drive, also serves as the busy flag |
| reject_o | output | 1 | Last evaluated program command was rejected |
| locked_o | output | 1 | Lock fuse state |
| test_fuse_o | output | 1 | Test fuse state |

## Verification
Assertions check the following on every cycle:
- fuses only ever set, never clear;
- at most one fuse changes per edge, and only when a burn strobe ends;
- every burn strobe lasts exactly BLOW_CYCLES;
- no burn starts while busy or after lock;
- the volatile registers stay frozen after lock;
- `safe_o` stays low while unlocked.

Other behaviour can only be shown by the bench scenarios. These cover the switch of the output source at lock, the rejection of zero-bit, multi-bit and out-of-range values, and a burn request dropped during a busy strobe, which stays absent from the fuses read after lock. They also cover the parity outcome with and without the parity fuse burnt.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int G2_W   = 3;
  localparam int G1_W   = 7;
  localparam int OF_W   = 8;
  localparam int VAL_W  = 8;
  localparam int CTL_W  = 3;
  localparam int DATA_W = G2_W + G1_W + OF_W;
  localparam int G2_LO  = 0;
  localparam int G1_LO  = G2_W;
  localparam int OF_LO  = G2_W + G1_W;
  localparam int MF_IDX = DATA_W;
  localparam int TF_IDX = DATA_W + 1;
  localparam int PF_IDX = DATA_W + 2;
  localparam int FUSE_W = DATA_W + CTL_W;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SIM   = 2'b01,
    OP_PROG  = 2'b10,
    OP_OTHER = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_G2  = 2'b00,
    SEL_G1  = 2'b01,
    SEL_OF  = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;
endpackage

// File: rtl/trim_cmd_decode.sv
module trim_cmd_decode
  import trim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [1:0]        cmd_sel_i,
  input  logic [VAL_W-1:0]  cmd_val_i,
  input  logic              locked_i,
  input  logic              busy_i,
  output logic [2:0]        sim_we_o,
  output logic              prog_go_o,
  output logic              prog_bad_o,
  output logic [FUSE_W-1:0] blow_mask_o
);
  localparam logic [VAL_W-1:0] RM_G2  = VAL_W'((1 << G2_W) - 1);
  localparam logic [VAL_W-1:0] RM_G1  = VAL_W'((1 << G1_W) - 1);
  localparam logic [VAL_W-1:0] RM_OF  = VAL_W'((1 << OF_W) - 1);
  localparam logic [VAL_W-1:0] RM_CTL = VAL_W'((1 << CTL_W) - 1);

  logic [VAL_W-1:0] range_mask;
  logic             single_bit;
  logic             in_range;
  logic             is_prog;
  logic             is_sim;

  always_comb begin
    range_mask  = RM_CTL;
    blow_mask_o = '0;
    unique case (cmd_sel_i)
      SEL_G2: begin
        range_mask = RM_G2;
        blow_mask_o[G2_LO +: G2_W] = cmd_val_i[G2_W-1:0];
      end
      SEL_G1: begin
        range_mask = RM_G1;
        blow_mask_o[G1_LO +: G1_W] = cmd_val_i[G1_W-1:0];
      end
      SEL_OF: begin
        range_mask = RM_OF;
        blow_mask_o[OF_LO +: OF_W] = cmd_val_i[OF_W-1:0];
      end
      default: begin
        range_mask = RM_CTL;
        blow_mask_o[MF_IDX +: CTL_W] = cmd_val_i[CTL_W-1:0];
      end
    endcase
  end

  always_comb begin
    single_bit  = (cmd_val_i != '0) && ((cmd_val_i & (cmd_val_i - 1'b1)) == '0);
    in_range    = (cmd_val_i & ~range_mask) == '0;
    is_prog     = cmd_valid_i && (cmd_op_i == OP_PROG) && !locked_i;
    is_sim      = cmd_valid_i && (cmd_op_i == OP_SIM) && !locked_i;
    prog_go_o   = is_prog && single_bit && in_range && !busy_i;
    prog_bad_o  = is_prog && !prog_go_o;
    sim_we_o[0] = is_sim && (cmd_sel_i == SEL_G2);
    sim_we_o[1] = is_sim && (cmd_sel_i == SEL_G1);
    sim_we_o[2] = is_sim && (cmd_sel_i == SEL_OF);
  end

  // R6
  single_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_go_o |-> $onehot0(blow_mask_o) && (blow_mask_o != '0));

  // R7
  no_go_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !prog_go_o);
endmodule

// File: rtl/trim_blow_timer.sv
module trim_blow_timer #(
  parameter int CYC = 16,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = start_i ? CW'(CYC) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == CW'(1);

  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= busy_o ? run_q + 1'b1 : '0;
  end

  // R6
  blow_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == (CW+1)'(CYC));

  // R7
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/trim_fuse_store.sv
module trim_fuse_store
  import trim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [FUSE_W-1:0] mask_i,
  input  logic              commit_i,
  output logic [FUSE_W-1:0] fuse_o
);
  logic [FUSE_W-1:0] pend_q, fuse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= '0;
    else if (arm_i) pend_q <= mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fuse_q <= '0;
    else if (commit_i) fuse_q <= fuse_q | pend_q;
  end

  assign fuse_o = fuse_q;

  // R6
  fuse_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fuse_q) & ~fuse_q) == '0);

  // R6
  one_fuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(fuse_q ^ $past(fuse_q)) <= 1);

  // R6
  commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_q != $past(fuse_q)) |-> $past(commit_i));
endmodule

// File: rtl/trim_fuse_bank.sv
module trim_fuse_bank
  import trim_pkg::*;
#(
  parameter int BLOW_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [1:0]       cmd_sel_i,
  input  logic [VAL_W-1:0] cmd_val_i,
  output logic [G2_W-1:0]  gain2_o,
  output logic [G1_W-1:0]  gain1_o,
  output logic [OF_W-1:0]  offset_o,
  output logic             safe_o,
  output logic             blow_o,
  output logic             reject_o,
  output logic             locked_o,
  output logic             test_fuse_o
);
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic [2:0]        sim_we;
  logic              prog_go, prog_bad, busy, done;
  logic [FUSE_W-1:0] blow_mask, fuse;

  trim_cmd_decode u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_sel_i   (cmd_sel_i),
    .cmd_val_i   (cmd_val_i),
    .locked_i    (locked_o),
    .busy_i      (busy),
    .sim_we_o    (sim_we),
    .prog_go_o   (prog_go),
    .prog_bad_o  (prog_bad),
    .blow_mask_o (blow_mask)
  );

  trim_blow_timer #(.CYC(BLOW_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (prog_go),
    .busy_o  (busy),
    .done_o  (done)
  );

  trim_fuse_store u_fuse (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .arm_i    (prog_go),
    .mask_i   (blow_mask),
    .commit_i (done),
    .fuse_o   (fuse)
  );

  logic [G2_W-1:0] g2_q;
  logic [G1_W-1:0] g1_q;
  logic [OF_W-1:0] of_q;
  logic            rej_q, rej_d, rej_en;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)         g2_q <= '0;
    else if (sim_we[0]) g2_q <= cmd_val_i[G2_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)         g1_q <= '0;
    else if (sim_we[1]) g1_q <= cmd_val_i[G1_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)         of_q <= '0;
    else if (sim_we[2]) of_q <= cmd_val_i[OF_W-1:0];
  end

  always_comb begin
    rej_en = prog_go || prog_bad;
    rej_d  = prog_bad;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      rej_q <= 1'b0;
    else if (rej_en) rej_q <= rej_d;
  end

  logic data_par;

  always_comb begin
    locked_o    = fuse[MF_IDX];
    test_fuse_o = fuse[TF_IDX];
    data_par    = ^fuse[DATA_W-1:0];
    safe_o      = locked_o & (data_par ^ fuse[PF_IDX]);
    blow_o      = busy;
    reject_o    = rej_q;
    if (locked_o) begin
      gain2_o  = fuse[G2_LO +: G2_W];
      gain1_o  = fuse[G1_LO +: G1_W];
      offset_o = fuse[OF_LO +: OF_W];
    end else begin
      gain2_o  = g2_q;
      gain1_o  = g1_q;
      offset_o = of_q;
    end
  end

  // R8
  no_perr_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !locked_o |-> !safe_o);

  // R4
  sim_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(locked_o) |-> $stable(g2_q) && $stable(g1_q) && $stable(of_q));

  // R9
  prog_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    locked_o |-> !prog_go && !prog_bad);

  // R5
  reject_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    prog_bad |=> reject_o && !$rose(blow_o));
endmodule

// File: tb/trim_fuse_bank_tb.sv
module trim_fuse_bank_tb_top;
  localparam int NCYC = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op, cmd_sel;
  logic [7:0] cmd_val;
  logic [2:0] gain2;
  logic [6:0] gain1;
  logic [7:0] offset;
  logic       safe, blow, reject, locked, tfuse;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  trim_fuse_bank #(.BLOW_CYCLES(NCYC)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_op_i    (cmd_op),
    .cmd_sel_i   (cmd_sel),
    .cmd_val_i   (cmd_val),
    .gain2_o     (gain2),
    .gain1_o     (gain1),
    .offset_o    (offset),
    .safe_o      (safe),
    .blow_o      (blow),
    .reject_o    (reject),
    .locked_o    (locked),
    .test_fuse_o (tfuse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_sel = 2'b00; cmd_val = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_val = val;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic count_blow(inout int n);
    for (int i = 0; i < 4 * NCYC && blow; i++) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic burn(input logic [1:0] sel, input logic [7:0] val, input string req);
    int n = 0;
    send(2'b10, sel, val);
    chk_eq({req, " reject cleared (R10)"}, reject, 0);
    count_blow(n);
    chk_eq({req, " blow length (R6)"}, n, NCYC);
  endtask

  task automatic t_reset();
    do_reset();
    chk_eq("R1 gain2", gain2, 0);
    chk_eq("R1 gain1", gain1, 0);
    chk_eq("R1 offset", offset, 0);
    chk_eq("R1 flags", {safe, blow, reject, locked, tfuse}, 0);
  endtask

  task automatic t_simulate();
    send(2'b01, 2'b00, 8'h03);
    send(2'b01, 2'b01, 8'h0B);
    send(2'b01, 2'b10, 8'h40);
    chk_eq("R2 gain2", gain2, 3);
    chk_eq("R2 gain1", gain1, 8'h0B);
    chk_eq("R2 offset", offset, 8'h40);
    send(2'b01, 2'b11, 8'hFF);
    chk_eq("R2 sel11 ignored", {gain2, gain1, offset}, {3'd3, 7'h0B, 8'h40});
  endtask

  task automatic t_rejects();
    send(2'b10, 2'b00, 8'h00);
    chk_eq("R5 zero value reject", reject, 1);
    chk_eq("R5 zero value no blow", blow, 0);
    send(2'b10, 2'b10, 8'h03);
    chk_eq("R5 two bits reject", {reject, blow}, 2'b10);
    send(2'b10, 2'b00, 8'h08);
    chk_eq("R5 out of range reject", {reject, blow}, 2'b10);
    send(2'b10, 2'b11, 8'h08);
    chk_eq("R5 ctl bit3 reject", {reject, blow}, 2'b10);
  endtask

  task automatic t_busy();
    int n = 0;
    send(2'b10, 2'b00, 8'h02);
    chk_eq("R10 accepted clears reject", reject, 0);
    n = 1;
    send(2'b10, 2'b01, 8'h40);
    chk_eq("R7 busy reject", reject, 1);
    n++;
    count_blow(n);
    chk_eq("R6 blow length busy case", n, NCYC);
    chk_eq("R3 fuse no effect while unlocked", {gain2, gain1, offset}, {3'd3, 7'h0B, 8'h40});
  endtask

  task automatic t_lock();
    burn(2'b00, 8'h01, "R6 g2b0");
    burn(2'b01, 8'h08, "R6 g1b3");
    burn(2'b10, 8'h80, "R6 ofb7");
    burn(2'b11, 8'h02, "R5 test fuse");
    chk_eq("R5 test fuse bit1", tfuse, 1);
    chk_eq("R3 outputs still volatile", {gain2, gain1, offset}, {3'd3, 7'h0B, 8'h40});
    chk_eq("R8 safe low unlocked", safe, 0);
    burn(2'b11, 8'h01, "R5 lock fuse");
    chk_eq("R4 locked", locked, 1);
    chk_eq("R4 gain2 from fuses", gain2, 3);
    chk_eq("R7 gain1 from fuses no busy bit", gain1, 8'h08);
    chk_eq("R4 offset from fuses", offset, 8'h80);
    chk_eq("R8 even parity no error", safe, 0);
    send(2'b01, 2'b00, 8'h00);
    chk_eq("R4 simulate ignored", gain2, 3);
    send(2'b10, 2'b10, 8'h01);
    chk_eq("R9 program ignored blow", blow, 0);
    chk_eq("R9 reject kept", reject, 0);
    repeat (NCYC + 2) @(negedge clk);
    chk_eq("R9 offset unchanged", offset, 8'h80);
    send(2'b10, 2'b10, 8'h03);
    chk_eq("R9 bad program ignored", reject, 0);
  endtask

  task automatic t_parity_err();
    do_reset();
    chk_eq("R1 fuses cleared", {locked, gain2, gain1, offset}, 0);
    burn(2'b10, 8'h01, "R6 odd data");
    chk_eq("R8 no error before lock", safe, 0);
    chk_eq("R3 fuse hidden", offset, 0);
    burn(2'b11, 8'h01, "R8 lock");
    chk_eq("R4 offset from fuses", offset, 1);
    chk_eq("R8 parity error", safe, 1);
  endtask

  task automatic t_parity_ok();
    do_reset();
    burn(2'b10, 8'h01, "R6 odd data");
    burn(2'b11, 8'h04, "R8 parity fuse");
    burn(2'b11, 8'h01, "R8 lock");
    chk_eq("R8 parity fuse matches", safe, 0);
    chk_eq("R4 offset", offset, 1);
  endtask

  initial begin
    t_reset();
    t_simulate();
    t_rejects();
    t_busy();
    t_lock();
    t_parity_err();
    t_parity_ok();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule